// File: doc/BRIEF.md
# Timer Gate Control Unit

This unit decides, cycle by cycle, whether a neighbouring counter may take its count tick. It selects one of four gate sources (an external gate pin, a single-cycle overflow pulse from an 8-bit timer, and two comparator outputs) and applies a selectable polarity. It can route the result through a toggle flip-flop so that a whole gate period is measured instead of one level. It also offers single-pulse acquisition: software arms it, and hardware disarms it when the measured pulse ends.

The live final gate level is always reported, even with gating switched off. A falling edge of that level sets a sticky event flag, which the host clears with a one-cycle clear strobe. The qualified tick output is the counter's tick, masked by the timer-on bit and, when gating is enabled, by the gate level. The pin and comparator inputs are asynchronous and pass through a synchronizer. The overflow pulse already belongs to the block's clock domain and is used directly.

Top module: `tgate_unit`

## Requirements
- R1: `src_sel_i` picks the gate source: 2'b00 gate pin, 2'b01 overflow pulse, 2'b10 comparator 1, 2'b11 comparator 2. A pin or comparator change reaches `gate_val_o` three clock edges after it is applied. An overflow pulse reaches it after one edge.
- R2: With `pol_sel_i`=1 the gate is active while the selected source is high. With `pol_sel_i`=0 it is active while the source is low.
- R3: `count_en_o` equals `count_tick_i` when `timer_on_i`=1 and `gate_en_i`=0. It equals `count_tick_i & gate_val_o` when both are 1. It is 0 whenever `timer_on_i`=0.
- R4: With `toggle_mode_i`=1, the gate value changes state on each rising edge of the polarity-adjusted source. With `toggle_mode_i`=0, the toggle flip-flop is cleared and held clear.
- R5: `timer_on_i`=0 clears the toggle flip-flop.
- R6: In single-pulse mode (`single_mode_i`=1), `gate_val_o` is 0 until `go_set_i` arms `go_busy_o`. The gate value then follows only the first gate pulse whose rising edge comes after arming. A pulse already active when armed is skipped. `go_busy_o` clears when that pulse ends, and later pulses are ignored.
- R7: With toggle and single-pulse modes both on, exactly one full gate period is passed, after which `go_busy_o` clears.
- R8: `gate_val_o` tracks the final gate level even while `gate_en_i`=0.
- R9: A falling edge of `gate_val_o` sets `gate_evt_o`, which stays set until `evt_clr_i`, also while `gate_en_i`=0. A set and a clear in the same cycle leave the flag set.
- R10: While `single_mode_i`=0, `go_busy_o` is forced to 0 and `go_set_i` is ignored.
- R11: A `go_set_i` in the same cycle as the hardware clear keeps `go_busy_o` set and re-arms for the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_pin_i | input | 1 | External gate pin (asynchronous) |
| ovf_pulse_i | input | 1 | One-cycle overflow pulse of an 8-bit timer |
| cmp1_i | input | 1 | Comparator 1 output (asynchronous) |
| cmp2_i | input | 1 | Comparator 2 output (asynchronous) |
| src_sel_i | input | 2 | Gate source select |
| gate_en_i | input | 1 | Counting is qualified by the gate |
| pol_sel_i | input | 1 | Gate polarity, 1 = active high |
| toggle_mode_i | input | 1 | Toggle flip-flop enable |
| single_mode_i | input | 1 | Single-pulse acquisition enable |
| go_set_i | input | 1 | Strobe that arms single-pulse acquisition |
| evt_clr_i | input | 1 | Strobe that clears the gate event flag |
| timer_on_i | input | 1 | Timer-on bit |
| count_tick_i | input | 1 | Counter's raw increment tick |
| count_en_o | output | 1 | Qualified increment tick |
| gate_val_o | output | 1 | Current final gate level |
| go_busy_o | output | 1 | Single-pulse acquisition armed or in progress |
| gate_evt_o | output | 1 | Sticky gate event flag |

## Verification
Two pairs of functions can collide in one cycle. The hardware setting of the event flag can meet the host's clear strobe, and the hardware clearing of the go bit can meet a software re-arm. The bench provokes each collision by counting the known three-edge path from a pin change to the gate value. It drives the strobe in exactly the cycle before the edge at which the gate value falls. It then judges that the flag, or the go bit, is still set after that edge. For the go bit, it also checks that the next pulse is measured.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_PIN  = 2'b00,
        SRC_OVF  = 2'b01,
        SRC_CMP1 = 2'b10,
        SRC_CMP2 = 2'b11
    } gate_src_e;

    typedef struct packed {
        logic pol;   // polarity-adjusted source
        logic tgl;   // toggle flip-flop
        logic stg;   // staged gate (toggle or direct)
        logic arm;   // single-pulse window open
        logic go;    // go/done
        logic gval;  // final gate level
        logic evt;   // sticky event flag
    } gate_state_t;
endpackage

// File: rtl/tgate_sync.sv
module tgate_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tgate_srcmux.sv
module tgate_srcmux
    import tgate_pkg::*;
(
    input  logic [SRC_W-1:0] sel_i,
    input  logic             pin_i,
    input  logic             ovf_i,
    input  logic             cmp1_i,
    input  logic             cmp2_i,
    output logic             src_o
);
    always_comb begin
        unique case (gate_src_e'(sel_i))
            SRC_PIN:  src_o = pin_i;
            SRC_OVF:  src_o = ovf_i;
            SRC_CMP1: src_o = cmp1_i;
            SRC_CMP2: src_o = cmp2_i;
            default:  src_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tgate_core.sv
module tgate_core
    import tgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic timer_on_i,
    input  logic pol_sel_i,
    input  logic toggle_i,
    input  logic single_i,
    input  logic go_set_i,
    input  logic evt_clr_i,
    output logic gval_o,
    output logic go_o,
    output logic evt_o
);
    gate_state_t s_d, s_q;
    logic pol_rise, stg_rise, stg_fall;

    always_comb begin
        s_d      = s_q;
        s_d.pol  = pol_sel_i ? src_i : ~src_i;
        pol_rise = s_d.pol & ~s_q.pol;

        if (!toggle_i || !timer_on_i) begin
            s_d.tgl = 1'b0;
        end else if (pol_rise) begin
            s_d.tgl = ~s_q.tgl;
        end

        s_d.stg  = toggle_i ? s_d.tgl : s_d.pol;
        stg_rise = s_d.stg & ~s_q.stg;
        stg_fall = ~s_d.stg & s_q.stg;

        s_d.arm = single_i & s_q.go & s_d.stg & (s_q.arm | stg_rise);

        if (!single_i) begin
            s_d.go = 1'b0;
        end else if (go_set_i) begin
            s_d.go = 1'b1;
        end else if (s_q.arm && stg_fall) begin
            s_d.go = 1'b0;
        end

        s_d.gval = single_i ? s_d.arm : s_d.stg;

        if (s_q.gval && !s_d.gval) begin
            s_d.evt = 1'b1;
        end else if (evt_clr_i) begin
            s_d.evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gval_o = s_q.gval;
    assign go_o   = s_q.go;
    assign evt_o  = s_q.evt;

    AST_TGL_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i || !timer_on_i) |=> !s_q.tgl); // R5
    AST_GO_NEEDS_SPM: assert property (@(posedge clk) disable iff (!rst_n)
        !single_i |=> !s_q.go); // R10
    AST_EVT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.gval) |-> s_q.evt); // R9
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.evt && !evt_clr_i) |=> s_q.evt); // R9
    AST_GO_ENDS_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.arm && single_i && !go_set_i) |=> (s_q.gval || !s_q.go)); // R6
endmodule

// File: rtl/tgate_unit.sv
module tgate_unit
    import tgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_pin_i,
    input  logic             ovf_pulse_i,
    input  logic             cmp1_i,
    input  logic             cmp2_i,
    input  logic [SRC_W-1:0] src_sel_i,
    input  logic             gate_en_i,
    input  logic             pol_sel_i,
    input  logic             toggle_mode_i,
    input  logic             single_mode_i,
    input  logic             go_set_i,
    input  logic             evt_clr_i,
    input  logic             timer_on_i,
    input  logic             count_tick_i,
    output logic             count_en_o,
    output logic             gate_val_o,
    output logic             go_busy_o,
    output logic             gate_evt_o
);
    localparam int NUM_ASYNC = 3;

    logic [NUM_ASYNC-1:0] async_raw, async_sync;
    logic                 src_sel;

    assign async_raw = {cmp2_i, cmp1_i, gate_pin_i};

    tgate_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(async_raw),
        .sync_o (async_sync)
    );

    tgate_srcmux i_mux (
        .sel_i (src_sel_i),
        .pin_i (async_sync[0]),
        .ovf_i (ovf_pulse_i),
        .cmp1_i(async_sync[1]),
        .cmp2_i(async_sync[2]),
        .src_o (src_sel)
    );

    tgate_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_sel),
        .timer_on_i(timer_on_i),
        .pol_sel_i (pol_sel_i),
        .toggle_i  (toggle_mode_i),
        .single_i  (single_mode_i),
        .go_set_i  (go_set_i),
        .evt_clr_i (evt_clr_i),
        .gval_o    (gate_val_o),
        .go_o      (go_busy_o),
        .evt_o     (gate_evt_o)
    );

    assign count_en_o = count_tick_i & timer_on_i & (~gate_en_i | gate_val_o);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_on_i |-> !count_en_o); // R3
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && !gate_val_o) |-> !count_en_o); // R3
endmodule

// File: tb/test_tgate_unit.sv
`timescale 1ns/1ps
module test_tgate_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 0, ovf = 0, c1 = 0, c2 = 0;
    logic [1:0] src = 2'b00;
    logic gen = 0, pol = 1, tgm = 0, spm = 0, go_set = 0, eclr = 0, ton = 0, tick = 0;
    logic cnt_en, gval, go, evt;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tgate_unit i_tgate_unit (
        .clk(clk), .rst_n(rst_n), .gate_pin_i(pin), .ovf_pulse_i(ovf),
        .cmp1_i(c1), .cmp2_i(c2), .src_sel_i(src), .gate_en_i(gen),
        .pol_sel_i(pol), .toggle_mode_i(tgm), .single_mode_i(spm),
        .go_set_i(go_set), .evt_clr_i(eclr), .timer_on_i(ton),
        .count_tick_i(tick), .count_en_o(cnt_en), .gate_val_o(gval),
        .go_busy_o(go), .gate_evt_o(evt)
    );

    // {expected, src[1:0], pol, pin, ovf, c1, c2}
    localparam logic [7:0] VEC [0:7] = '{
        8'b10011000, 8'b00001000, 8'b10110100, 8'b00111011,
        8'b11010010, 8'b01000111, 8'b01111110, 8'b11100000
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic clear_evt();
        eclr = 1; step(1); eclr = 0; step(1);
    endtask

    task automatic pulse_pin();
        pin = 1; step(4); pin = 0; step(4);
    endtask

    task automatic arm_go();
        go_set = 1; step(1); go_set = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        // reset state
        check("R9 reset evt", evt, 1'b0);
        check("R6 reset go", go, 1'b0);
        check("R8 reset gval", gval, 1'b0);
        check("R3 reset cnt_en", cnt_en, 1'b0);
        rst_n = 1; ton = 1; step(4); clear_evt();

        // R1 / R2 source and polarity table
        for (int i = 0; i < 8; i++) begin
            {src, pol, pin, ovf, c1, c2} = VEC[i][6:0];
            step(4);
            check("R1 R2 table", gval, VEC[i][7]);
        end
        src = 2'b00; pol = 1; pin = 0; ovf = 0; c1 = 0; c2 = 0;
        step(4); clear_evt();

        // R1 overflow pulse: one-edge latency
        src = 2'b01; ovf = 1; step(1); ovf = 0;
        check("R1 ovf pulse high", gval, 1'b1);
        step(1);
        check("R1 ovf pulse low", gval, 1'b0);
        check("R9 evt after ovf pulse", evt, 1'b1);
        src = 2'b00; clear_evt();

        // R3 count qualification
        tick = 1; gen = 0; step(1);
        check("R3 ungated tick", cnt_en, 1'b1);
        gen = 1; step(1);
        check("R3 gate closed", cnt_en, 1'b0);
        pin = 1; step(3);
        check("R3 gate open", cnt_en, 1'b1);
        ton = 0; step(1);
        check("R3 timer off", cnt_en, 1'b0);
        ton = 1;

        // R8 / R9 with gating disabled
        gen = 0; step(1);
        check("R8 gval with gate_en=0", gval, 1'b1);
        pin = 0; step(3);
        check("R8 gval falls", gval, 1'b0);
        check("R9 evt set gate_en=0", evt, 1'b1);
        step(5);
        check("R9 evt sticky", evt, 1'b1);
        clear_evt();
        check("R9 evt cleared", evt, 1'b0);

        // R9 set and clear in the same cycle
        pin = 1; step(4); pin = 0; step(2);
        eclr = 1; step(1); eclr = 0;
        check("R9 set wins over clear", evt, 1'b1);
        clear_evt();

        // R4 toggle mode
        tgm = 1; step(2);
        pulse_pin();
        check("R4 toggle first edge", gval, 1'b1);
        pulse_pin();
        check("R4 toggle second edge", gval, 1'b0);
        pulse_pin();
        check("R4 toggle third edge", gval, 1'b1);
        tgm = 0; step(2);
        check("R4 toggle off clears", gval, 1'b0);
        tgm = 1; step(2);
        check("R4 flop held clear", gval, 1'b0);
        pulse_pin();
        check("R4 toggle after re-enable", gval, 1'b1);
        ton = 0; step(2);
        check("R5 timer off clears flop", gval, 1'b0);
        ton = 1; step(2);
        check("R5 flop stays clear", gval, 1'b0);
        tgm = 0; step(2); clear_evt();

        // R6 single pulse
        spm = 1; gen = 1; tick = 1; step(2);
        pin = 1; step(4);
        check("R6 no go no gate", gval, 1'b0);
        check("R6 no go no count", cnt_en, 1'b0);
        pin = 0; step(4);
        arm_go();
        check("R6 go armed", go, 1'b1);
        pin = 1; step(4);
        check("R6 pulse passes", gval, 1'b1);
        check("R6 pulse counts", cnt_en, 1'b1);
        pin = 0; step(4);
        check("R6 pulse end gval", gval, 1'b0);
        check("R6 go self-clears", go, 1'b0);
        check("R9 evt after single pulse", evt, 1'b1);
        pin = 1; step(4);
        check("R6 later pulse ignored", gval, 1'b0);
        pin = 0; step(4); clear_evt();

        // R6 pulse already active when armed
        pin = 1; step(4);
        arm_go(); step(4);
        check("R6 active pulse skipped", gval, 1'b0);
        check("R6 go still armed", go, 1'b1);
        pin = 0; step(4);
        check("R6 go kept after skipped pulse", go, 1'b1);
        pin = 1; step(4);
        check("R6 next pulse passes", gval, 1'b1);
        pin = 0; step(4);
        check("R6 go cleared after next pulse", go, 1'b0);
        clear_evt();

        // R11 software set coincides with hardware clear
        arm_go();
        pin = 1; step(4);
        check("R11 pulse passes", gval, 1'b1);
        pin = 0; step(2);
        go_set = 1; step(1); go_set = 0;
        check("R11 go kept set", go, 1'b1);
        check("R11 gval fell", gval, 1'b0);
        pin = 1; step(4);
        check("R11 re-armed pulse passes", gval, 1'b1);
        pin = 0; step(4);
        check("R11 go cleared afterwards", go, 1'b0);
        clear_evt();

        // R7 toggle plus single pulse
        tgm = 1; step(2);
        arm_go();
        pulse_pin();
        check("R7 first edge opens", gval, 1'b1);
        check("R7 go still busy", go, 1'b1);
        pin = 1; step(4);
        check("R7 second edge closes", gval, 1'b0);
        check("R7 go cleared", go, 1'b0);
        pin = 0; step(4);
        pulse_pin();
        check("R7 no further period", gval, 1'b0);
        tgm = 0; step(2); clear_evt();

        // R10 go forced low without single-pulse mode
        arm_go();
        check("R10 go armed", go, 1'b1);
        spm = 0; step(1);
        check("R10 go forced low", go, 1'b0);
        arm_go();
        check("R10 go_set ignored", go, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule